// File: doc/BRIEF.md
# Host/Microcontroller Parameter Memory Mailbox

This block lets a host processor and an on-card microcontroller share a 128-byte battery-backed parameter store. The host reaches the store through two 8-bit I/O ports. A write to the index port loads a 7-bit storage pointer, and a read of the same port returns a status byte. The data port reads or writes the byte at the current pointer. The microcontroller has its own address, data and strobe pins, and it can reach every location of the same array.

Two freshness flags tell each agent that the other has placed new data in the store. The host flag is raised by a microcontroller write and dropped by a host read of the data port. The microcontroller flag is raised by an accepted host write and dropped by a microcontroller read. These two flags share the status byte with two clock-lock indications, a microcontroller access request and two microcontroller status flags. Bytes that the microcontroller keeps up to date, such as identification, version, feature and sensor values, are protected from host writes.

Top module: `nvram_mailbox`

## Requirements
- R1: A host write (`host_wr`) with `host_io_addr` equal to 0x7E loads `host_wdata[6:0]` into the storage pointer. The new pointer selects the data-port byte from the next cycle on.
- R2: A host write with `host_io_addr` equal to 0x7F stores `host_wdata` at the pointer, and the byte can be read from the next cycle on. While `host_io_addr` is 0x7F, `host_rdata` shows the byte at the pointer in the same cycle.
- R3: While `host_io_addr` is 0x7E, `host_rdata` is the status byte. Its bits, from bit 0 up, are: host flag, system clock locked, disk clock locked, microcontroller request, microcontroller flag, constant 0, S0, S1. Bits 1, 2, 3, 6 and 7 follow `sys_clk_ok`, `dsk_clk_ok`, `mc_req`, `mc_s0` and `mc_s1` in the same cycle.
- R4: A microcontroller write (`mc_we`) sets status bit 0 from the next cycle on. A host read (`host_rd`) of port 0x7F clears it from the next cycle on.
- R5: An accepted host data write sets status bit 4 from the next cycle on. A microcontroller read (`mc_re`) clears it from the next cycle on.
- R6: When a flag's set event and clear event fall in the same cycle, the set wins and the flag reads 1 afterwards.
- R7: Host writes to locations 0x76, 0x77, 0x78 and 0x7B through 0x7F are ignored: the byte stays unchanged and status bit 4 is not set. Host writes to 0x75, 0x79 and 0x7A, and to every location below 0x75, are accepted.
- R8: The microcontroller can write any location. When both agents write the same location in the same cycle, the microcontroller's byte is stored, and both bit 0 and bit 4 become 1.
- R9: Synchronous reset (`rst` high) clears the pointer and both flags. A host I/O address other than 0x7E or 0x7F has no effect, and `host_rdata` then reads 0.
- R10: `mc_rdata` shows the byte at `mc_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_io_addr | input | 8 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (status or storage byte) |
| mc_addr | input | 7 | Microcontroller storage address |
| mc_wdata | input | 8 | Microcontroller write data |
| mc_we | input | 1 | Microcontroller write strobe |
| mc_re | input | 1 | Microcontroller read strobe |
| mc_rdata | output | 8 | Byte at `mc_addr` |
| mc_req | input | 1 | Microcontroller requests storage access |
| sys_clk_ok | input | 1 | System clock locked to its setting |
| dsk_clk_ok | input | 1 | Disk-controller clock locked to its setting |
| mc_s0 | input | 1 | Microcontroller status flag S0 (1 = temperature reading complete) |
| mc_s1 | input | 1 | Microcontroller status flag S1 |

## Verification
Both read paths are combinational, so `host_rdata` and `mc_rdata` are due in the same cycle as the address that selects them. Every write, pointer load and flag change becomes visible exactly one edge after its strobe. The bench therefore drives each cycle's inputs just after a falling edge and compares both read buses against its reference model shortly before the next rising edge. It updates the model at that rising edge, so a stimulus is first checked in the following cycle. Directed sequences cover collisions, protected locations and flag races. A randomized run then compares every cycle.

// File: rtl/nvmbx_pkg.sv
package nvmbx_pkg;
    parameter int ADDR_W = 7;
    parameter int DATA_W = 8;
    parameter int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] nv_addr_t;
    typedef logic [DATA_W-1:0] nv_byte_t;

    // status byte bit positions
    localparam int ST_HOST_FRESH = 0;
    localparam int ST_SYS_LOCK   = 1;
    localparam int ST_DSK_LOCK   = 2;
    localparam int ST_MC_REQ     = 3;
    localparam int ST_MC_FRESH   = 4;
    localparam int ST_ZERO       = 5;
    localparam int ST_S0         = 6;
    localparam int ST_S1         = 7;

    // locations owned by the microcontroller: host writes are dropped
    function automatic logic host_ro(nv_addr_t a);
        return ((a >= nv_addr_t'(8'h76)) && (a <= nv_addr_t'(8'h78))) ||
               (a >= nv_addr_t'(8'h7B));
    endfunction
endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
    import nvmbx_pkg::*;
#(
    parameter logic [7:0] STATUS_PORT = 8'h7E,
    parameter logic [7:0] DATA_PORT   = 8'h7F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] io_addr,
    input  logic       wr,
    input  logic       rd,
    input  nv_addr_t   wptr,
    output nv_addr_t   ptr_q,
    output logic       sel_status,
    output logic       sel_data,
    output logic       data_wr,
    output logic       data_rd
);
    typedef struct packed {
        nv_addr_t ptr;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        sel_status = (io_addr == STATUS_PORT);
        sel_data   = (io_addr == DATA_PORT);
        data_wr    = wr && sel_data;
        data_rd    = rd && sel_data;
        st_d       = st_q;
        if (wr && sel_status) begin
            st_d.ptr = wptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q = st_q.ptr;

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && (io_addr == STATUS_PORT)) |=> (ptr_q == $past(wptr))); // R1
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && (io_addr == STATUS_PORT)) |=> $stable(ptr_q)); // R9
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_status, sel_data})); // R9
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import nvmbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     host_wr_req,
    input  nv_addr_t host_addr,
    input  nv_byte_t host_wdata,
    output nv_byte_t host_rbyte,
    output logic     host_acc,
    input  logic     mc_we,
    input  nv_addr_t mc_addr,
    input  nv_byte_t mc_wdata,
    output nv_byte_t mc_rbyte
);
    nv_byte_t mem_d [DEPTH];
    nv_byte_t mem_q [DEPTH];

    always_comb begin
        host_acc   = host_wr_req && !host_ro(host_addr);
        host_rbyte = mem_q[host_addr];
        mc_rbyte   = mem_q[mc_addr];
    end

    // per-location next value; microcontroller write applied last so it wins
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_comb begin
            mem_d[g] = mem_q[g];
            if (host_acc && (host_addr == nv_addr_t'(g))) begin
                mem_d[g] = host_wdata;
            end
            if (mc_we && (mc_addr == nv_addr_t'(g))) begin
                mem_d[g] = mc_wdata;
            end
        end
    end

    // battery-backed contents: not cleared by reset
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    AST_MC_WINS: assert property (@(posedge clk) disable iff (rst)
        mc_we |=> (mem_q[$past(mc_addr)] == $past(mc_wdata))); // R8
    AST_RO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (host_wr_req && host_ro(host_addr) && !(mc_we && (mc_addr == host_addr)))
        |=> (mem_q[$past(host_addr)] == $past(mem_q[host_addr]))); // R7
    AST_HOST_STORE: assert property (@(posedge clk) disable iff (rst)
        (host_acc && !(mc_we && (mc_addr == host_addr)))
        |=> (mem_q[$past(host_addr)] == $past(host_wdata))); // R2
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
    import nvmbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mc_we,
    input  logic     mc_re,
    input  logic     host_acc,
    input  logic     host_data_rd,
    input  logic     sys_clk_ok,
    input  logic     dsk_clk_ok,
    input  logic     mc_req,
    input  logic     mc_s0,
    input  logic     mc_s1,
    output nv_byte_t status
);
    typedef struct packed {
        logic host_fresh;
        logic mc_fresh;
    } flag_st_t;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // clear first, then set: a coincident set prevails
        if (host_data_rd) fl_d.host_fresh = 1'b0;
        if (mc_we)        fl_d.host_fresh = 1'b1;
        if (mc_re)        fl_d.mc_fresh   = 1'b0;
        if (host_acc)     fl_d.mc_fresh   = 1'b1;

        status                = '0;
        status[ST_HOST_FRESH] = fl_q.host_fresh;
        status[ST_SYS_LOCK]   = sys_clk_ok;
        status[ST_DSK_LOCK]   = dsk_clk_ok;
        status[ST_MC_REQ]     = mc_req;
        status[ST_MC_FRESH]   = fl_q.mc_fresh;
        status[ST_S0]         = mc_s0;
        status[ST_S1]         = mc_s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    AST_HOST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        mc_we |=> status[ST_HOST_FRESH]); // R4
    AST_HOST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (host_data_rd && !mc_we) |=> !status[ST_HOST_FRESH]); // R4
    AST_MC_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        host_acc |=> status[ST_MC_FRESH]); // R5
    AST_MC_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (mc_re && !host_acc) |=> !status[ST_MC_FRESH]); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mc_we && !host_data_rd) |=> $stable(status[ST_HOST_FRESH])); // R6
endmodule

// File: rtl/nvram_mailbox.sv
module nvram_mailbox
    import nvmbx_pkg::*;
#(
    parameter logic [7:0] STATUS_PORT = 8'h7E,
    parameter logic [7:0] DATA_PORT   = 8'h7F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           host_io_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic [ADDR_W-1:0]    mc_addr,
    input  logic [DATA_W-1:0]    mc_wdata,
    input  logic                 mc_we,
    input  logic                 mc_re,
    output logic [DATA_W-1:0]    mc_rdata,
    input  logic                 mc_req,
    input  logic                 sys_clk_ok,
    input  logic                 dsk_clk_ok,
    input  logic                 mc_s0,
    input  logic                 mc_s1
);
    nv_addr_t ptr_q;
    logic     sel_status, sel_data, data_wr, data_rd, host_acc;
    nv_byte_t host_rbyte, status;

    mbx_host_port #(.STATUS_PORT(STATUS_PORT), .DATA_PORT(DATA_PORT)) port_i (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (host_io_addr),
        .wr         (host_wr),
        .rd         (host_rd),
        .wptr       (host_wdata[ADDR_W-1:0]),
        .ptr_q      (ptr_q),
        .sel_status (sel_status),
        .sel_data   (sel_data),
        .data_wr    (data_wr),
        .data_rd    (data_rd)
    );

    mbx_store store_i (
        .clk         (clk),
        .rst         (rst),
        .host_wr_req (data_wr),
        .host_addr   (ptr_q),
        .host_wdata  (host_wdata),
        .host_rbyte  (host_rbyte),
        .host_acc    (host_acc),
        .mc_we       (mc_we),
        .mc_addr     (mc_addr),
        .mc_wdata    (mc_wdata),
        .mc_rbyte    (mc_rdata)
    );

    mbx_flags flags_i (
        .clk          (clk),
        .rst          (rst),
        .mc_we        (mc_we),
        .mc_re        (mc_re),
        .host_acc     (host_acc),
        .host_data_rd (data_rd),
        .sys_clk_ok   (sys_clk_ok),
        .dsk_clk_ok   (dsk_clk_ok),
        .mc_req       (mc_req),
        .mc_s0        (mc_s0),
        .mc_s1        (mc_s1),
        .status       (status)
    );

    always_comb begin
        host_rdata = '0;
        if (sel_status) begin
            host_rdata = status;
        end else if (sel_data) begin
            host_rdata = host_rbyte;
        end
    end

    AST_STATUS_ZERO_BIT: assert property (@(posedge clk) disable iff (rst)
        sel_status |-> (host_rdata[ST_ZERO] == 1'b0)); // R3
    AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
        (!sel_status && !sel_data) |-> (host_rdata == '0)); // R9
endmodule

// File: tb/nvram_mailbox_tb.sv
module nvram_mailbox_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] host_io_addr;
    logic       host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata;
    logic [6:0] mc_addr;
    logic [7:0] mc_wdata, mc_rdata;
    logic       mc_we, mc_re, mc_req, sys_clk_ok, dsk_clk_ok, mc_s0, mc_s1;

    always #5 clk = ~clk;

    nvram_mailbox dut_i (
        .clk(clk), .rst(rst), .host_io_addr(host_io_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mc_addr(mc_addr), .mc_wdata(mc_wdata), .mc_we(mc_we), .mc_re(mc_re),
        .mc_rdata(mc_rdata), .mc_req(mc_req), .sys_clk_ok(sys_clk_ok),
        .dsk_clk_ok(dsk_clk_ok), .mc_s0(mc_s0), .mc_s1(mc_s1)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model
    logic [7:0] m_mem [128];
    bit         m_val [128];
    logic [6:0] m_ptr;
    bit         m_hf, m_mf;

    function automatic bit ro(logic [6:0] a);
        return (a == 7'h76) || (a == 7'h77) || (a == 7'h78) || (a >= 7'h7B);
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {mc_s1, mc_s0, 1'b0, m_mf, mc_req, dsk_clk_ok, sys_clk_ok, m_hf};
    endfunction

    task automatic idle();
        host_io_addr = 8'h00; host_wr = 0; host_rd = 0; host_wdata = 0;
        mc_we = 0; mc_re = 0; mc_wdata = 0;
    endtask

    // compare outputs, then advance one clock with the model
    task automatic step(string req);
        #2;
        if (host_io_addr == 8'h7E) check(req, host_rdata, m_status());
        else if (host_io_addr == 8'h7F) begin
            if (m_val[m_ptr]) check(req, host_rdata, m_mem[m_ptr]);
        end else check("R9", host_rdata, 8'h00);
        if (m_val[mc_addr]) check("R10", mc_rdata, m_mem[mc_addr]);
        @(posedge clk);
        if (rst) begin
            m_ptr = 0; m_hf = 0; m_mf = 0;
        end else begin
            bit acc;
            acc = host_wr && host_io_addr == 8'h7F && !ro(m_ptr);
            if (host_rd && host_io_addr == 8'h7F) m_hf = 0;
            if (mc_we) m_hf = 1;
            if (mc_re) m_mf = 0;
            if (acc) m_mf = 1;
            if (acc) begin m_mem[m_ptr] = host_wdata; m_val[m_ptr] = 1; end
            if (mc_we) begin m_mem[mc_addr] = mc_wdata; m_val[mc_addr] = 1; end
            if (host_wr && host_io_addr == 8'h7E) m_ptr = host_wdata[6:0];
        end
        @(negedge clk);
        idle();
    endtask

    task automatic h_ptr(logic [6:0] a, string req);
        host_io_addr = 8'h7E; host_wr = 1; host_wdata = {1'b0, a}; step(req);
    endtask
    task automatic h_wr(logic [7:0] d, string req);
        host_io_addr = 8'h7F; host_wr = 1; host_wdata = d; step(req);
    endtask
    task automatic h_rd(string req);
        host_io_addr = 8'h7F; host_rd = 1; step(req);
    endtask
    task automatic h_st(string req);
        host_io_addr = 8'h7E; host_rd = 1; step(req);
    endtask
    task automatic m_wr(logic [6:0] a, logic [7:0] d, string req);
        mc_addr = a; mc_wdata = d; mc_we = 1; step(req);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        foreach (m_val[i]) m_val[i] = 0;
        m_ptr = 0; m_hf = 0; m_mf = 0;
        idle();
        mc_addr = 0; mc_req = 0; sys_clk_ok = 0; dsk_clk_ok = 0; mc_s0 = 0; mc_s1 = 0;
        rst = 1;
        @(negedge clk); step("R9"); step("R9");
        rst = 0;
        // R9 reset state: status all zero
        host_io_addr = 8'h7E; #2; check("R9", host_rdata, 8'h00); @(negedge clk);
        idle();
        // R1, R2, R5, R10
        h_ptr(7'h10, "R1");
        h_wr(8'hA5, "R2");
        h_rd("R2");
        host_io_addr = 8'h7E; #2; check("R5", host_rdata[4], 1'b1); @(negedge clk); idle();
        mc_addr = 7'h10; mc_re = 1; #2; check("R10", mc_rdata, 8'hA5); step("R10");
        host_io_addr = 8'h7E; #2; check("R5", host_rdata[4], 1'b0); @(negedge clk); idle();
        // R4
        m_wr(7'h20, 8'h3C, "R4");
        host_io_addr = 8'h7E; #2; check("R4", host_rdata[0], 1'b1); @(negedge clk); idle();
        h_ptr(7'h20, "R1");
        h_rd("R4");
        host_io_addr = 8'h7E; #2; check("R4", host_rdata[0], 1'b0); @(negedge clk); idle();
        // R3 status inputs in several patterns
        for (int p = 0; p < 32; p++) begin
            {mc_s1, mc_s0, mc_req, dsk_clk_ok, sys_clk_ok} = 5'(p);
            h_st("R3");
        end
        // R7 protected location keeps microcontroller value, flag not set
        m_wr(7'h7D, 8'h11, "R8");
        h_ptr(7'h7D, "R1");
        h_wr(8'hFF, "R7");
        mc_addr = 7'h7D; #2; check("R7", mc_rdata, 8'h11); @(negedge clk); idle();
        host_io_addr = 8'h7E; #2; check("R7", host_rdata[4], 1'b0); @(negedge clk); idle();
        foreach (m_val[i]) if (i >= 'h75) begin
            h_ptr(7'(i), "R1"); h_wr(8'(i ^ 8'h5A), "R7"); h_rd("R7");
        end
        // R8 collision: microcontroller byte wins, both flags set
        h_ptr(7'h30, "R1");
        host_io_addr = 8'h7F; host_wr = 1; host_wdata = 8'hAA;
        mc_addr = 7'h30; mc_wdata = 8'h55; mc_we = 1; step("R8");
        h_rd("R8");
        mc_addr = 7'h30; #2; check("R8", mc_rdata, 8'h55); @(negedge clk); idle();
        // R6 host read against microcontroller write: bit 0 stays set
        host_io_addr = 8'h7F; host_rd = 1; mc_addr = 7'h31; mc_wdata = 8'h01; mc_we = 1; step("R6");
        host_io_addr = 8'h7E; #2; check("R6", host_rdata[0], 1'b1); @(negedge clk); idle();
        // R6 microcontroller read against host write: bit 4 stays set
        host_io_addr = 8'h7F; host_wr = 1; host_wdata = 8'h77; mc_re = 1; step("R6");
        host_io_addr = 8'h7E; #2; check("R6", host_rdata[4], 1'b1); @(negedge clk); idle();
        // R9 foreign port has no effect
        host_io_addr = 8'h50; host_wr = 1; host_wdata = 8'h05; step("R9");
        host_io_addr = 8'h50; host_rd = 1; step("R9");
        h_rd("R9");
        // randomized cross-check every cycle
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 5);
            {mc_s1, mc_s0, mc_req, dsk_clk_ok, sys_clk_ok} = 5'($urandom);
            mc_addr = 7'($urandom);
            mc_wdata = 8'($urandom);
            mc_we = ($urandom_range(0, 3) == 0);
            mc_re = ($urandom_range(0, 3) == 0);
            host_wdata = 8'($urandom);
            case (op)
                0: host_io_addr = 8'h7E;
                1: begin host_io_addr = 8'h7E; host_wr = 1; end
                2: begin host_io_addr = 8'h7E; host_rd = 1; end
                3: begin host_io_addr = 8'h7F; host_wr = 1; end
                4: begin host_io_addr = 8'h7F; host_rd = 1; end
                default: begin host_io_addr = 8'($urandom); host_wr = 1; end
            endcase
            step(op == 3 ? "R2" : (op == 4 ? "R4" : "R3"));
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule